// File: doc/BRIEF.md
# Interrupt Exception Entry Controller

This block is the interrupt front end of a small 32-bit soft processor. It latches a set of level-sensitive request lines into a pending register. Each pending bit is qualified by a per-line mask bit. When an unmasked request is pending, the global enable is set and the core signals an instruction boundary, the block raises an exception-take indication. All lines share one handler entry point, placed at a fixed offset above a programmable, 256-byte aligned base.

On the clock edge that takes the exception, the block stores the next-instruction address as the resume address. It also copies the global enable into a saved-enable bit and clears the global enable. A nested entry is therefore impossible until software restores the enable. A return pulse copies the saved-enable bit back into the global enable, and the resume address stays available as the return target. Software reaches pending, mask, control and base through a small CSR port, and reads pending and mask to pick the line to serve.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After a synchronous reset, pending, mask, both enable bits, the base and the resume address are all zero, and no exception is taken.
- R2: A request line that is high at a clock edge sets its pending bit, which is visible in the CSR read of select 0 from the following cycle.
- R3: A CSR write to select 0 clears each pending bit whose data bit is 1 and leaves the others alone. A bit whose line is still high at that edge stays set.
- R4: The mask register is written and read at CSR select 1, with bit i gating line i. An exception is requested only when (pending AND mask) is nonzero.
- R5: `take_exc` is asserted only while `insn_boundary` is high and the global enable is set.
- R6: The base register is written at CSR select 3 and keeps only data bits 31..8; it reads back with bits 7..0 as zero. `vector_pc` equals the base plus 0xC0.
- R7: On a take edge, the resume address is loaded from `next_pc`, the saved-enable bit gets the old global enable, and the global enable is cleared.
- R8: After an entry, no further exception is taken until the global enable is set again (no nesting).
- R9: An `eret` pulse sets the global enable to the saved-enable bit, and `resume_pc` presents the stored resume address.
- R10: The control register is at CSR select 2, with bit 0 the global enable and bit 1 the saved-enable. A CSR write to it in the same cycle as an entry is discarded in favour of the entry update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-high interrupt request lines |
| insn_boundary | input | 1 | Strobe marking an instruction boundary where an exception may be taken |
| next_pc | input | 32 | Address of the next instruction, saved on entry |
| eret | input | 1 | Return-from-exception pulse |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR select: 0 pending, 1 mask, 2 control, 3 base |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for the selected register |
| take_exc | output | 1 | Exception taken at this boundary |
| vector_pc | output | 32 | Handler entry address (base + 0xC0) |
| resume_pc | output | 32 | Stored resume address for the return |

## Verification
Exception entry and a software write to the control register can fall in the same cycle. Both want to change the global enable. The bench provokes this by driving a boundary with an unmasked pending request and, in the same cycle, a control write that sets the enable. It judges the result by reading the control register afterwards, which must show the enable cleared and the saved-enable set, and by confirming that a second boundary takes nothing. A second collision, a line held high while its pending bit is being cleared, is checked by reading that bit back as still set.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int XLEN     = 32;
    localparam int BASE_LSB = 8;
    localparam logic [XLEN-1:0] VEC_OFFSET = 32'h0000_00C0;

    typedef enum logic [1:0] {
        CSR_PEND = 2'd0,
        CSR_MASK = 2'd1,
        CSR_CTL  = 2'd2,
        CSR_BASE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic saved_en;   // bit 1
        logic glob_en;    // bit 0
    } ctl_t;

    function automatic logic [XLEN-1:0] entry_addr(input logic [XLEN-1:BASE_LSB] base);
        return {base, {BASE_LSB{1'b0}}} + VEC_OFFSET;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] req,
    input  logic              clr_we,
    input  logic [NLINES-1:0] clr_bits,
    input  logic              mask_we,
    input  logic [NLINES-1:0] mask_wdata,
    output logic [NLINES-1:0] pend_q,
    output logic [NLINES-1:0] mask_q,
    output logic              active
);
    logic [NLINES-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;
    assign active  = |(pend_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_eff) | req;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // R2: every line high at an edge is pending afterwards
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> ((pend_q & $past(req)) == $past(req)));

    // R3: cleared bits with a quiet line are gone afterwards
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((pend_q & $past(clr_bits & ~req)) == '0));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     boundary,
    input  logic                     active,
    input  logic [XLEN-1:0]          next_pc,
    input  logic                     eret,
    input  logic                     ctl_we,
    input  ctl_t                     ctl_wdata,
    input  logic                     base_we,
    input  logic [XLEN-1:BASE_LSB]   base_wdata,
    output logic                     take,
    output ctl_t                     ctl_q,
    output logic [XLEN-1:BASE_LSB]   base_q,
    output logic [XLEN-1:0]          ea_q,
    output logic [XLEN-1:0]          vector_pc
);
    assign take      = boundary & ctl_q.glob_en & active;
    assign vector_pc = entry_addr(base_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            base_q <= '0;
            ea_q   <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (take) begin
                ea_q           <= next_pc;
                ctl_q.saved_en <= ctl_q.glob_en;
                ctl_q.glob_en  <= 1'b0;
            end else if (eret) begin
                ctl_q.glob_en  <= ctl_q.saved_en;
            end else if (ctl_we) begin
                ctl_q          <= ctl_wdata;
            end
        end
    end

    // R7: entry stores resume address and moves enable to saved
    p_entry_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (ea_q == $past(next_pc) && ctl_q.saved_en && !ctl_q.glob_en));

    // R8: no back-to-back entry
    p_no_nest_r8: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R9: return restores enable from the saved bit
    p_eret_r9: assert property (@(posedge clk) disable iff (rst)
        (eret && !take) |=> (ctl_q.glob_en == $past(ctl_q.saved_en)));

    // R10: software write loses to entry
    p_write_loses_r10: assert property (@(posedge clk) disable iff (rst)
        (take && ctl_we) |=> !ctl_q.glob_en);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 insn_boundary,
    input  logic [XLEN-1:0]      next_pc,
    input  logic                 eret,
    input  logic                 csr_we,
    input  logic [1:0]           csr_sel,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    output logic                 take_exc,
    output logic [XLEN-1:0]      vector_pc,
    output logic [XLEN-1:0]      resume_pc
);
    csr_sel_e               sel;
    logic [NUM_LINES-1:0]   pend_q, mask_q;
    logic                   active;
    ctl_t                   ctl_q;
    logic [XLEN-1:BASE_LSB] base_q;

    assign sel = csr_sel_e'(csr_sel);

    irq_pend_bank #(.NLINES(NUM_LINES)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .req        (irq_lines),
        .clr_we     (csr_we && sel == CSR_PEND),
        .clr_bits   (csr_wdata[NUM_LINES-1:0]),
        .mask_we    (csr_we && sel == CSR_MASK),
        .mask_wdata (csr_wdata[NUM_LINES-1:0]),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .active     (active)
    );

    irq_entry_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .boundary   (insn_boundary),
        .active     (active),
        .next_pc    (next_pc),
        .eret       (eret),
        .ctl_we     (csr_we && sel == CSR_CTL),
        .ctl_wdata  (ctl_t'(csr_wdata[1:0])),
        .base_we    (csr_we && sel == CSR_BASE),
        .base_wdata (csr_wdata[XLEN-1:BASE_LSB]),
        .take       (take_exc),
        .ctl_q      (ctl_q),
        .base_q     (base_q),
        .ea_q       (resume_pc),
        .vector_pc  (vector_pc)
    );

    always_comb begin
        unique case (sel)
            CSR_PEND: csr_rdata = XLEN'(pend_q);
            CSR_MASK: csr_rdata = XLEN'(mask_q);
            CSR_CTL:  csr_rdata = XLEN'(ctl_q);
            CSR_BASE: csr_rdata = {base_q, {BASE_LSB{1'b0}}};
            default:  csr_rdata = '0;
        endcase
    end

    // R5: an exception needs a boundary strobe
    p_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        !insn_boundary |-> !take_exc);
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_lines;
    logic        insn_boundary;
    logic [31:0] next_pc;
    logic        eret;
    logic        csr_we;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        take_exc;
    logic [31:0] vector_pc;
    logic [31:0] resume_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_entry_ctrl i_irq_entry_ctrl (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .insn_boundary(insn_boundary),
        .next_pc(next_pc), .eret(eret), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .take_exc(take_exc),
        .vector_pc(vector_pc), .resume_pc(resume_pc)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] irq;
        logic        gie;
        logic        bnd;
        logic        exp_take;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_00F0, 32'h0000_0010, 1'b1, 1'b1, 1'b1},
        '{32'h0000_00F0, 32'h0000_0001, 1'b1, 1'b1, 1'b0},
        '{32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
        '{32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 1'b0},
        '{32'h8000_0001, 32'h8000_0000, 1'b1, 1'b1, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [31:0] data);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic csr_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        csr_sel = sel;
        #1;
        check(req, csr_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_lines = '0; insn_boundary = 1'b0; next_pc = '0;
        eret = 1'b0; csr_we = 1'b0; csr_sel = 2'd0; csr_wdata = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;

        // R1: reset state
        csr_chk("R1 pending", 2'd0, 32'h0);
        csr_chk("R1 mask",    2'd1, 32'h0);
        csr_chk("R1 control", 2'd2, 32'h0);
        csr_chk("R1 base",    2'd3, 32'h0);
        check("R1 resume", resume_pc, 32'h0);
        check("R1 vector", vector_pc, 32'h0000_00C0);
        insn_boundary = 1'b1; #1;
        check("R1 take", {31'b0, take_exc}, 32'h0);
        insn_boundary = 1'b0;

        // R2 R4 R5: vector table
        for (int i = 0; i < NVEC; i++) begin
            csr_wr(2'd0, 32'hFFFF_FFFF);
            csr_wr(2'd1, VECS[i].mask);
            csr_wr(2'd2, {31'b0, VECS[i].gie});
            irq_lines = VECS[i].irq;
            tick();
            irq_lines = '0;
            csr_chk("R2 pending capture", 2'd0, VECS[i].irq);
            csr_chk("R4 mask readback", 2'd1, VECS[i].mask);
            insn_boundary = VECS[i].bnd;
            #1;
            check("R4/R5 take gating", {31'b0, take_exc}, {31'b0, VECS[i].exp_take});
            insn_boundary = 1'b0;
        end

        // R3: write-1-clear, held line stays set
        csr_wr(2'd2, 32'h0);
        csr_wr(2'd0, 32'hFFFF_FFFF);
        irq_lines = 32'h0000_0009;
        tick();
        csr_wr(2'd0, 32'h0000_0008);
        csr_chk("R3 held line stays pending", 2'd0, 32'h0000_0009);
        irq_lines = '0;
        csr_wr(2'd0, 32'h0000_0008);
        csr_chk("R3 only written bit cleared", 2'd0, 32'h0000_0001);

        // R6: base alignment and vector
        csr_wr(2'd3, 32'h1234_56FF);
        csr_chk("R6 base readback", 2'd3, 32'h1234_5600);
        check("R6 vector", vector_pc, 32'h1234_56C0);

        // R7 R10: entry colliding with control write
        csr_wr(2'd1, 32'h0000_0001);
        csr_wr(2'd2, 32'h1);
        insn_boundary = 1'b1;
        next_pc = 32'hA000_0004;
        csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'h1;
        #1;
        check("R5 take at boundary", {31'b0, take_exc}, 32'h1);
        tick();
        csr_we = 1'b0; insn_boundary = 1'b0;
        csr_chk("R10 write loses to entry", 2'd2, 32'h2);
        check("R7 resume address", resume_pc, 32'hA000_0004);

        // R8: no nesting while enable is clear
        insn_boundary = 1'b1; #1;
        check("R8 no nested take", {31'b0, take_exc}, 32'h0);
        insn_boundary = 1'b0;

        // R9: return restores enable
        eret = 1'b1;
        tick();
        eret = 1'b0;
        csr_chk("R9 enable restored", 2'd2, 32'h3);
        check("R9 resume target", resume_pc, 32'hA000_0004);
        insn_boundary = 1'b1; #1;
        check("R9 take allowed again", {31'b0, take_exc}, 32'h1);
        insn_boundary = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule